// File: doc/BRIEF.md
# DDR SDRAM Command Spacing Monitor

This block sits beside the command bus of a four-bank DDR SDRAM clocked at 133 MHz (7.5 ns period). On every clock it decodes chip select, the row strobe, the column strobe, write enable, the two bank bits and address bit 10 into one command. It tracks for each bank whether a row is open, and keeps a set of countdown windows per bank plus two shared windows. A command that comes before its required spacing, or that does not suit the current bank state, is reported one clock later as a single-cycle flag with a one-hot reason code.

Each minimum spacing is a parameter in picoseconds and is rounded up to whole clock periods. Every decoded command updates the tracked state, whether or not it was flagged, so the monitor follows what the memory would do and keeps checking the commands after it. The asynchronous active-low reset is released through a two-stage synchronizer. The monitor therefore treats the first two clocks after release as reset.

Top module: `ddr_cmd_guard`

## Requirements
- R1: After reset all banks are idle and every window has expired. `viol_valid` and `viol_code` are 0. A deselect (`cs_n`=1) or a no-op (`cs_n`=0 with the three strobes high) never raises a flag.
- R2: Commands decode as follows, with `cs_n`=0 and {`ras_n`,`cas_n`,`we_n`}: 011 activate, 101 read, 100 write, 010 precharge, 001 refresh, 000 mode-register set, 110 burst stop. `ba` selects the bank (0 through 3). Each bank's state is independent of the others.
- R3: A read or write must come at least 3 cycles after the activate of the same bank.
- R4: An activate must come at least 3 cycles after a precharge that closed the same bank. A precharge to an idle bank changes no state.
- R5: On the same bank, a precharge must come at least 6 cycles after an activate, and a second activate at least 9 cycles after the first.
- R6: Two activates, to any banks, must be at least 2 cycles apart.
- R7: A precharge must come at least 5 cycles after a write to the same open bank. This is 1 cycle of write latency, 2 data cycles and 2 cycles of recovery.
- R8: A precharge with `a10`=1 ignores `ba`. It checks the precharge window of every open bank and closes all of them.
- R9: A mode-register set with any bank open is flagged. After a mode-register set, no command other than a no-op may come for 2 cycles.
- R10: A refresh with any bank open is flagged. After a refresh, no other command may come for 10 cycles. A refresh or mode-register set with all banks idle must also come at least 3 cycles after the last bank closed.
- R11: The flag and code appear in the cycle after the command. The code bits are: bit 0 too early, bit 1 activate to an open bank, bit 2 bank not active, bit 3 banks open at refresh or mode-register set. A state reason takes priority over the early reason, so at most one bit is set. The code is 0 whenever the flag is low.
- R12: An activate to an open bank gives code 4'b0010. A read or write to an idle bank gives 4'b0100 and changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank select |
| a10 | input | 1 | Address bit 10 (all-bank precharge) |
| viol_valid | output | 1 | One-cycle violation flag |
| viol_code | output | 4 | One-hot violation reason |

## Verification
The bound checker watches the fixed facts on every cycle:
- the code is one-hot while the flag is high, and zero otherwise;
- no-ops stay quiet;
- an all-bank precharge leaves no bank open;
- an activate leaves its bank open;
- reads and writes to idle banks, and activates to open banks, give their state codes;
- an activate right after a mode-register set or a refresh is too early.

The multi-cycle windows have counts that differ from command to command and can overlap: row-to-column, row active, row cycle, precharge, write recovery, refresh and the spacing between banks. Only the bench's timestamp model shows that these expire on exactly the right cycle. It checks them with directed sequences that probe one cycle before and at each boundary, and with a long random command stream.

// File: rtl/ddr_guard_pkg.sv
package ddr_guard_pkg;

  typedef enum logic [2:0] {
    CMD_NOP,
    CMD_ACT,
    CMD_RD,
    CMD_WR,
    CMD_PRE,
    CMD_REF,
    CMD_MRS,
    CMD_BST
  } cmd_e;

  localparam int CODE_W        = 4;
  localparam int VB_EARLY      = 0;
  localparam int VB_NOT_IDLE   = 1;
  localparam int VB_NOT_ACTIVE = 2;
  localparam int VB_OPEN_BANKS = 3;

  // picoseconds to whole clock periods, rounded up
  function automatic int ps_to_cyc(input int ps, input int clk_ps);
    return (ps + clk_ps - 1) / clk_ps;
  endfunction

endpackage

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
  import ddr_guard_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);

  always_comb begin
    if (cs_n) begin
      cmd = CMD_NOP;
    end else begin
      unique case ({ras_n, cas_n, we_n})
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = CMD_RD;
        3'b100:  cmd = CMD_WR;
        3'b010:  cmd = CMD_PRE;
        3'b001:  cmd = CMD_REF;
        3'b000:  cmd = CMD_MRS;
        3'b110:  cmd = CMD_BST;
        default: cmd = CMD_NOP;
      endcase
    end
  end

endmodule

// File: rtl/ddr_bank_slot.sv
module ddr_bank_slot
  import ddr_guard_pkg::*;
#(
  parameter int CW    = 5,
  parameter int RCD_C = 3,
  parameter int RAS_C = 6,
  parameter int RC_C  = 9,
  parameter int RP_C  = 3,
  parameter int WRP_C = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  cmd_e cmd,
  input  logic pre_all,
  output logic is_open,
  output logic rw_ready,
  output logic pre_ready,
  output logic act_ready,
  output logic rp_ready
);

  localparam logic [CW-1:0] L_RCD = CW'(RCD_C - 1);
  localparam logic [CW-1:0] L_RAS = CW'(RAS_C - 1);
  localparam logic [CW-1:0] L_RC  = CW'(RC_C - 1);
  localparam logic [CW-1:0] L_RP  = CW'(RP_C - 1);
  localparam logic [CW-1:0] L_WRP = CW'(WRP_C - 1);

  logic          open_q, open_d;
  logic [CW-1:0] rw_q, rw_d;
  logic [CW-1:0] pre_q, pre_d;
  logic [CW-1:0] act_q, act_d;
  logic [CW-1:0] rp_q, rp_d;
  logic          do_act, do_wr, do_close;

  function automatic logic [CW-1:0] dec_sat(input logic [CW-1:0] v);
    return (v == '0) ? '0 : v - 1'b1;
  endfunction

  function automatic logic [CW-1:0] max_of(input logic [CW-1:0] x,
                                           input logic [CW-1:0] y);
    return (x > y) ? x : y;
  endfunction

  assign do_act   = hit && (cmd == CMD_ACT);
  assign do_wr    = hit && (cmd == CMD_WR) && open_q;
  assign do_close = open_q && (cmd == CMD_PRE) && (hit || pre_all);

  always_comb begin
    open_d = open_q;
    rw_d   = dec_sat(rw_q);
    pre_d  = dec_sat(pre_q);
    act_d  = dec_sat(act_q);
    rp_d   = dec_sat(rp_q);
    if (do_act) begin
      open_d = 1'b1;
      rw_d   = max_of(rw_d, L_RCD);
      pre_d  = max_of(pre_d, L_RAS);
      act_d  = max_of(act_d, L_RC);
    end
    if (do_wr) begin
      pre_d = max_of(pre_d, L_WRP);
    end
    if (do_close) begin
      open_d = 1'b0;
      rp_d   = max_of(rp_d, L_RP);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      rw_q   <= '0;
      pre_q  <= '0;
      act_q  <= '0;
      rp_q   <= '0;
    end else begin
      open_q <= open_d;
      rw_q   <= rw_d;
      pre_q  <= pre_d;
      act_q  <= act_d;
      rp_q   <= rp_d;
    end
  end

  assign is_open   = open_q;
  assign rw_ready  = (rw_q == '0);
  assign pre_ready = (pre_q == '0);
  assign act_ready = (act_q == '0) && (rp_q == '0);
  assign rp_ready  = (rp_q == '0);

endmodule

// File: rtl/ddr_global_window.sv
module ddr_global_window
  import ddr_guard_pkg::*;
#(
  parameter int CW    = 5,
  parameter int MRD_C = 2,
  parameter int RFC_C = 10,
  parameter int RRD_C = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  cmd_e cmd,
  output logic glob_ready,
  output logic rrd_ready
);

  localparam logic [CW-1:0] L_MRD = CW'(MRD_C - 1);
  localparam logic [CW-1:0] L_RFC = CW'(RFC_C - 1);
  localparam logic [CW-1:0] L_RRD = CW'(RRD_C - 1);

  logic [CW-1:0] glob_q, glob_d;
  logic [CW-1:0] rrd_q, rrd_d;

  always_comb begin
    glob_d = (glob_q == '0) ? '0 : glob_q - 1'b1;
    rrd_d  = (rrd_q == '0) ? '0 : rrd_q - 1'b1;
    if (cmd == CMD_MRS && glob_d < L_MRD) glob_d = L_MRD;
    if (cmd == CMD_REF && glob_d < L_RFC) glob_d = L_RFC;
    if (cmd == CMD_ACT && rrd_d < L_RRD)  rrd_d  = L_RRD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glob_q <= '0;
      rrd_q  <= '0;
    end else begin
      glob_q <= glob_d;
      rrd_q  <= rrd_d;
    end
  end

  assign glob_ready = (glob_q == '0);
  assign rrd_ready  = (rrd_q == '0);

endmodule

// File: rtl/ddr_cmd_guard.sv
module ddr_cmd_guard
  import ddr_guard_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int CLK_PS    = 7500,
  parameter int RCD_PS    = 20000,
  parameter int RP_PS     = 20000,
  parameter int RAS_PS    = 45000,
  parameter int RC_PS     = 65000,
  parameter int RRD_PS    = 15000,
  parameter int RFC_PS    = 75000,
  parameter int WR_PS     = 15000,
  parameter int MRD_CYC   = 2,
  parameter int BURST_LEN = 4,
  parameter int WR_LAT    = 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cs_n,
  input  logic                  ras_n,
  input  logic                  cas_n,
  input  logic                  we_n,
  input  logic [1:0]            ba,
  input  logic                  a10,
  output logic                  viol_valid,
  output logic [CODE_W-1:0]     viol_code
);

  localparam int BA_W  = $clog2(NUM_BANKS);
  localparam int RCD_C = ps_to_cyc(RCD_PS, CLK_PS);
  localparam int RP_C  = ps_to_cyc(RP_PS, CLK_PS);
  localparam int RAS_C = ps_to_cyc(RAS_PS, CLK_PS);
  localparam int RC_C  = ps_to_cyc(RC_PS, CLK_PS);
  localparam int RRD_C = ps_to_cyc(RRD_PS, CLK_PS);
  localparam int RFC_C = ps_to_cyc(RFC_PS, CLK_PS);
  localparam int WRP_C = WR_LAT + BURST_LEN / 2 + ps_to_cyc(WR_PS, CLK_PS);
  localparam int CW    = $clog2(RC_C + RFC_C + WRP_C + RAS_C + MRD_CYC + 1);

  logic                 rst_meta, rst_sync;
  cmd_e                 cmd;
  logic [NUM_BANKS-1:0] open_vec, rw_rdy, pre_rdy, act_rdy, rp_rdy;
  logic                 glob_rdy, rrd_rdy;
  logic                 early;
  logic [CODE_W-1:0]    code_d;
  logic                 valid_q;
  logic [CODE_W-1:0]    code_q;

  // reset: asserted at once, released on the second clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  ddr_cmd_decode u_dec (
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .cmd   (cmd)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    ddr_bank_slot #(
      .CW    (CW),
      .RCD_C (RCD_C),
      .RAS_C (RAS_C),
      .RC_C  (RC_C),
      .RP_C  (RP_C),
      .WRP_C (WRP_C)
    ) u_slot (
      .clk       (clk),
      .rst_n     (rst_sync),
      .hit       (ba[BA_W-1:0] == BA_W'(b)),
      .cmd       (cmd),
      .pre_all   (a10),
      .is_open   (open_vec[b]),
      .rw_ready  (rw_rdy[b]),
      .pre_ready (pre_rdy[b]),
      .act_ready (act_rdy[b]),
      .rp_ready  (rp_rdy[b])
    );
  end

  ddr_global_window #(
    .CW    (CW),
    .MRD_C (MRD_CYC),
    .RFC_C (RFC_C),
    .RRD_C (RRD_C)
  ) u_glob (
    .clk        (clk),
    .rst_n      (rst_sync),
    .cmd        (cmd),
    .glob_ready (glob_rdy),
    .rrd_ready  (rrd_rdy)
  );

  // classify the current command: state reasons first, then spacing
  always_comb begin
    code_d = '0;
    early  = 1'b0;
    unique case (cmd)
      CMD_ACT: begin
        if (open_vec[ba[BA_W-1:0]]) code_d[VB_NOT_IDLE] = 1'b1;
        else early = !glob_rdy || !rrd_rdy || !act_rdy[ba[BA_W-1:0]];
      end
      CMD_RD, CMD_WR: begin
        if (!open_vec[ba[BA_W-1:0]]) code_d[VB_NOT_ACTIVE] = 1'b1;
        else early = !glob_rdy || !rw_rdy[ba[BA_W-1:0]];
      end
      CMD_PRE: begin
        if (a10) early = !glob_rdy || |(open_vec & ~pre_rdy);
        else if (open_vec[ba[BA_W-1:0]])
          early = !glob_rdy || !pre_rdy[ba[BA_W-1:0]];
        else early = !glob_rdy;
      end
      CMD_REF, CMD_MRS: begin
        if (|open_vec) code_d[VB_OPEN_BANKS] = 1'b1;
        else early = !glob_rdy || !(&rp_rdy);
      end
      CMD_BST: early = !glob_rdy;
      default: early = 1'b0;
    endcase
    if (code_d == '0 && early) code_d[VB_EARLY] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      valid_q <= 1'b0;
      code_q  <= '0;
    end else begin
      valid_q <= |code_d;
      code_q  <= code_d;
    end
  end

  assign viol_valid = valid_q;
  assign viol_code  = code_q;

endmodule

// File: rtl/ddr_cmd_guard_chk.sv
module ddr_cmd_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       ras_n,
  input logic       cas_n,
  input logic       we_n,
  input logic [1:0] ba,
  input logic       a10,
  input logic [3:0] open_vec,
  input logic       viol_valid,
  input logic [3:0] viol_code
);

  logic c_nop, c_act, c_rw, c_pre, c_ref, c_mrs;
  assign c_nop = cs_n || (ras_n && cas_n && we_n);
  assign c_act = !cs_n && !ras_n && cas_n && we_n;
  assign c_rw  = !cs_n && ras_n && !cas_n;
  assign c_pre = !cs_n && !ras_n && cas_n && !we_n;
  assign c_ref = !cs_n && !ras_n && !cas_n && we_n;
  assign c_mrs = !cs_n && !ras_n && !cas_n && !we_n;

  p_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    viol_valid |-> $countones(viol_code) == 1);

  p_quiet_code_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !viol_valid |-> viol_code == 4'b0000);

  p_nop_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
    c_nop |=> !viol_valid);

  p_pre_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (c_pre && a10) |=> open_vec == 4'b0000);

  p_act_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
    c_act |=> open_vec[$past(ba)]);

  p_rw_closed_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (c_rw && !open_vec[ba]) |=> viol_code == 4'b0100);

  p_act_open_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (c_act && open_vec[ba]) |=> viol_code == 4'b0010);

  p_mrs_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    c_mrs ##1 (c_act && !open_vec[ba]) |=> viol_code == 4'b0001);

  p_ref_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    c_ref ##1 (c_act && !open_vec[ba]) |=> viol_code == 4'b0001);

endmodule

bind ddr_cmd_guard ddr_cmd_guard_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cs_n       (cs_n),
  .ras_n      (ras_n),
  .cas_n      (cas_n),
  .we_n       (we_n),
  .ba         (ba),
  .a10        (a10),
  .open_vec   (open_vec),
  .viol_valid (viol_valid),
  .viol_code  (viol_code)
);

// File: tb/tb_ddr_cmd_guard.sv
`timescale 1ns/1ps
module tb_ddr_cmd_guard;

  localparam int K_NOP = 0, K_ACT = 1, K_RD = 2, K_WR = 3, K_PRE = 4,
                 K_REF = 5, K_MRS = 6, K_BST = 7, K_DES = 8;
  localparam int G_RCD = 3, G_RP = 3, G_RAS = 6, G_RC = 9, G_RRD = 2,
                 G_MRD = 2, G_RFC = 10, G_WRP = 5;

  logic clk = 1'b0;
  logic rst_n;
  logic cs_n, ras_n, cas_n, we_n, a10;
  logic [1:0] ba;
  logic viol_valid;
  logic [3:0] viol_code;

  always #2.5 clk = ~clk;

  ddr_cmd_guard dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .a10(a10), .viol_valid(viol_valid),
    .viol_code(viol_code)
  );

  int vecs = 0, bad = 0, now = 0;
  int u_rw[4], u_pre[4], u_act[4], u_rp[4];
  bit opn[4];
  int g_until = 0, r_until = 0;
  bit pend = 0;
  logic [3:0] exp_code;
  string cur_req = "R1";

  function automatic int mx(input int x, input int y);
    return (x > y) ? x : y;
  endfunction

  // timestamp model: each window is the first cycle at which it is legal
  function automatic logic [3:0] model(input int c, input int b, input bit a);
    logic [3:0] code = 4'b0;
    bit early = 0;
    bit anyopen = opn[0] | opn[1] | opn[2] | opn[3];
    case (c)
      K_ACT: begin
        if (opn[b]) code = 4'b0010;
        else early = now < g_until || now < r_until || now < u_act[b] || now < u_rp[b];
        u_rw[b] = mx(u_rw[b], now + G_RCD);
        u_pre[b] = mx(u_pre[b], now + G_RAS);
        u_act[b] = mx(u_act[b], now + G_RC);
        r_until = mx(r_until, now + G_RRD);
        opn[b] = 1;
      end
      K_RD, K_WR: begin
        if (!opn[b]) code = 4'b0100;
        else begin
          early = now < g_until || now < u_rw[b];
          if (c == K_WR) u_pre[b] = mx(u_pre[b], now + G_WRP);
        end
      end
      K_PRE: begin
        early = now < g_until;
        for (int i = 0; i < 4; i++) begin
          if (opn[i] && (a || i == b)) begin
            if (now < u_pre[i]) early = 1;
            u_rp[i] = mx(u_rp[i], now + G_RP);
            opn[i] = 0;
          end
        end
      end
      K_REF, K_MRS: begin
        if (anyopen) code = 4'b1000;
        else begin
          early = now < g_until;
          for (int i = 0; i < 4; i++) if (now < u_rp[i]) early = 1;
        end
        g_until = mx(g_until, now + ((c == K_REF) ? G_RFC : G_MRD));
      end
      K_BST: early = now < g_until;
      default: ;
    endcase
    if (code == 4'b0 && early) code = 4'b0001;
    return code;
  endfunction

  task automatic drive(input int c, input int b, input bit a);
    logic [2:0] s;
    case (c)
      K_ACT: s = 3'b011;  K_RD:  s = 3'b101;  K_WR:  s = 3'b100;
      K_PRE: s = 3'b010;  K_REF: s = 3'b001;  K_MRS: s = 3'b000;
      K_BST: s = 3'b110;  K_DES: s = 3'($urandom_range(0, 7));
      default: s = 3'b111;
    endcase
    cs_n = (c == K_DES);
    {ras_n, cas_n, we_n} = s;
    ba = 2'(b);
    a10 = a;
  endtask

  task automatic compare();
    vecs++;
    if (viol_valid !== (exp_code != 4'b0) || viol_code !== exp_code) begin
      bad++;
      $display("FAIL %s t=%0d: valid=%b code=%b, expected valid=%b code=%b",
               cur_req, now, viol_valid, viol_code, exp_code != 4'b0, exp_code);
    end
  endtask

  task automatic step(input int c, input int b, input bit a);
    @(negedge clk);
    if (pend) compare();
    exp_code = model(c, b, a);
    pend = 1;
    drive(c, b, a);
    now++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(K_NOP, i % 4, 0);
  endtask

  initial begin
    #1000000;
    bad++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin
      u_rw[i] = 0; u_pre[i] = 0; u_act[i] = 0; u_rp[i] = 0; opn[i] = 0;
    end
    rst_n = 1'b0;
    drive(K_NOP, 0, 0);
    // R1: reset state
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      exp_code = 4'b0;
      compare();
    end
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) @(negedge clk);

    // R1: no-ops and deselects with random strobes stay quiet
    cur_req = "R1";
    for (int i = 0; i < 8; i++) step((i % 2) ? K_DES : K_NOP, i % 4, i[0]);

    // R2: bank mapping, each bank opened and read on its own
    cur_req = "R2";
    for (int b = 0; b < 4; b++) begin step(K_ACT, b, 0); step(K_NOP, 0, 0); end
    for (int b = 0; b < 4; b++) step(K_RD, b, 0);
    idle(4);
    for (int b = 0; b < 4; b++) step(K_PRE, b, 0);
    idle(10);

    // R3: activate to read, one cycle short then exact
    cur_req = "R3";
    step(K_ACT, 1, 0); idle(1); step(K_RD, 1, 0); step(K_WR, 1, 0);
    idle(8); step(K_PRE, 1, 1); idle(4);

    // R4: precharge to activate, plus precharge of an idle bank
    cur_req = "R4";
    step(K_ACT, 2, 0); idle(9); step(K_PRE, 2, 0); idle(1);
    step(K_ACT, 2, 0); idle(9); step(K_PRE, 2, 0); idle(2);
    step(K_ACT, 2, 0); step(K_PRE, 3, 0); idle(2); step(K_RD, 3, 0);
    idle(6); step(K_PRE, 2, 0); idle(4);

    // R5: activate to precharge and row cycle
    cur_req = "R5";
    step(K_ACT, 0, 0); idle(4); step(K_PRE, 0, 0); idle(1);
    step(K_ACT, 0, 0); idle(2); step(K_ACT, 0, 0);
    idle(5); step(K_PRE, 0, 0); idle(12);

    // R6: activate spacing across banks
    cur_req = "R6";
    step(K_ACT, 0, 0); step(K_ACT, 1, 0); step(K_ACT, 2, 0);
    idle(8); step(K_PRE, 0, 1); idle(4);

    // R7: write recovery before precharge
    cur_req = "R7";
    step(K_ACT, 3, 0); idle(5); step(K_WR, 3, 0); idle(3); step(K_PRE, 3, 0);
    idle(2); step(K_ACT, 3, 0); idle(2); step(K_WR, 3, 0); idle(5);
    step(K_WR, 3, 0); idle(4); step(K_PRE, 3, 0); idle(4);

    // R8: all-bank precharge checks every open bank
    cur_req = "R8";
    step(K_ACT, 0, 0); idle(6); step(K_ACT, 1, 0); idle(1);
    step(K_PRE, 2, 1); idle(3); step(K_RD, 0, 0); step(K_RD, 1, 0); idle(4);

    // R9: mode set needs idle banks and a gap
    cur_req = "R9";
    step(K_MRS, 0, 0); step(K_ACT, 0, 0); step(K_MRS, 1, 0); idle(8);
    step(K_PRE, 0, 1); idle(4); step(K_MRS, 0, 0); step(K_NOP, 0, 0);
    step(K_ACT, 1, 0); idle(6); step(K_PRE, 1, 0); idle(4);

    // R10: refresh needs idle banks, tRP after close and a long gap
    cur_req = "R10";
    step(K_REF, 0, 0); idle(8); step(K_BST, 0, 0); step(K_REF, 0, 0);
    idle(10); step(K_ACT, 2, 0); step(K_REF, 0, 0); idle(9);
    step(K_PRE, 2, 0); idle(1); step(K_REF, 0, 0); idle(12);

    // R12: state codes
    cur_req = "R12";
    step(K_WR, 1, 0); step(K_ACT, 1, 0); idle(9); step(K_ACT, 1, 0);
    idle(6); step(K_PRE, 1, 0); step(K_RD, 1, 0); idle(4);

    // R11: random stream
    cur_req = "R11";
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 15);
      int c;
      if (r < 7) c = K_NOP;
      else if (r < 9) c = K_ACT;
      else if (r == 9) c = K_RD;
      else if (r == 10) c = K_WR;
      else if (r < 13) c = K_PRE;
      else if (r == 13) c = ($urandom_range(0, 3) == 0) ? K_REF : K_DES;
      else if (r == 14) c = ($urandom_range(0, 3) == 0) ? K_MRS : K_NOP;
      else c = K_BST;
      step(c, $urandom_range(0, 3), $urandom_range(0, 3) == 0);
    end
    step(K_NOP, 0, 0);
    @(negedge clk);
    compare();

    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

endmodule